// File: doc/BRIEF.md
# Clock-Line Idle Timeout Monitor

This block watches the clock wire of a shared two-wire serial bus. From that wire alone it decides whether another master is currently driving the bus. Every level change on the wire, rising or falling, restarts a timeout counter. When the counter runs out with no further activity, the bus is declared idle. A master that wants to start a bus acquisition looks at the idle flag and begins only while it is high. The block needs no start or stop condition decoding and no knowledge of the data wire.

The raw wire level passes through a two-flop synchronizer before edge detection. The timeout length is a programmable input wide enough for very long windows, so masters with very different clock rates can share the bus. Each restart of the counter captures the timeout value, so a new value on the input only matters from the next restart onward. A one-cycle pulse marks the moment the bus turns idle.

Top module: `scl_idle_monitor`

## Requirements
- R1: While reset is high, `bus_idle_o` and `idle_pulse_o` are both 0 on the next clock edge, even if the bus was idle before.
- R2: After reset is released with no wire activity, `bus_idle_o` rises on the (T+1)-th clock edge after release, where T is the `timeout_i` value present during reset.
- R3: A rising level change on `scl_i` restarts the timeout: `bus_idle_o` is 0 from the third clock edge after the change.
- R4: A falling level change on `scl_i` restarts the timeout exactly as a rising change does.
- R5: After a restart, with no further change on the wire, `bus_idle_o` stays 0 and rises on clock edge T+4 counted from the wire change. It then stays 1 until the next wire change.
- R6: `idle_pulse_o` is 1 for exactly one cycle, in the cycle in which `bus_idle_o` goes from 0 to 1, and is 0 at all other times.
- R7: If a restart falls in the same cycle in which the timeout would expire, the restart wins: `bus_idle_o` stays 0, no pulse is produced, and a fresh full timeout begins.
- R8: A change of `timeout_i` between restarts does not alter the window in progress. The new value is used from the next restart.
- R9: The full width of `timeout_i` is usable. With all ones, the bus becomes idle after 2^CNT_W clock edges plus the synchronizer delay, and the counter does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw, asynchronous level of the bus clock wire |
| timeout_i | input | CNT_W | Timeout length T in system clock cycles, captured at each restart |
| bus_idle_o | output | 1 | 1 while the bus is considered free for a new acquisition |
| idle_pulse_o | output | 1 | One-cycle marker of the busy-to-idle change |

## Verification
Two events can land in the same cycle: a counter restart from a wire edge, and expiry of the timeout window. The bench sets T=6 and toggles the wire. It then toggles the wire again exactly seven cycles later, so that the second restart is applied in the cycle where the first window would have ended. It judges the outcome by checking that the idle flag and pulse stay low in that cycle and that idle arrives a full window after the second edge.

// File: rtl/busmon_pkg.sv
package busmon_pkg;

    // Bus ownership state reported by the monitor
    typedef enum logic {
        BUS_BUSY = 1'b0,
        BUS_IDLE = 1'b1
    } bus_state_e;

    // Resting level of the clock wire on an idle two-wire bus
    localparam logic SCL_REST_LEVEL = 1'b1;

    // Synchronizer depth used by default
    localparam int DEF_SYNC_STAGES = 2;

    // True when the running count has reached the captured limit
    function automatic logic window_done(input logic [63:0] cnt, input logic [63:0] lim);
        return (cnt == lim);
    endfunction

endpackage

// File: rtl/busmon_sync.sv
module busmon_sync
    import busmon_pkg::*;
#(
    parameter int STAGES = DEF_SYNC_STAGES
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) stage_q[0] <= SCL_REST_LEVEL;
                    else       stage_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) stage_q[i] <= SCL_REST_LEVEL;
                    else       stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/busmon_edge.sv
module busmon_edge
    import busmon_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic lvl_i,
    output logic edge_o
);

    logic prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= SCL_REST_LEVEL;
        else       prev_q <= lvl_i;
    end

    // Either direction of change counts as activity
    assign edge_o = lvl_i ^ prev_q;

endmodule

// File: rtl/busmon_timer.sv
module busmon_timer
    import busmon_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             edge_i,
    input  logic [CNT_W-1:0] timeout_i,
    output bus_state_e       state_o,
    output logic             pulse_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        bus_state_e       st;
        logic             pulse;
    } tmr_t;

    tmr_t q, nx;
    logic expire;

    assign expire = window_done(64'(q.cnt), 64'(q.lim));

    always_comb begin
        nx       = q;
        nx.pulse = 1'b0;
        if (edge_i) begin
            nx.cnt = '0;
            nx.lim = timeout_i;
            nx.st  = BUS_BUSY;
        end else if (q.st == BUS_BUSY) begin
            if (expire) begin
                nx.st    = BUS_IDLE;
                nx.pulse = 1'b1;
            end else begin
                nx.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q.cnt   <= '0;
            q.lim   <= timeout_i;
            q.st    <= BUS_BUSY;
            q.pulse <= 1'b0;
        end else begin
            q <= nx;
        end
    end

    assign state_o = q.st;
    assign pulse_o = q.pulse;

    // R5
    cnt_within_limit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (q.st == BUS_BUSY) |-> (q.cnt <= q.lim));

    // R3
    edge_clears_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        edge_i |=> (q.st == BUS_BUSY));

    // R7
    edge_no_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        edge_i |=> !q.pulse);

    // R5
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((q.st == BUS_IDLE) && !edge_i) |=> (q.st == BUS_IDLE));

    // R8
    limit_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !edge_i |=> $stable(q.lim));

endmodule

// File: rtl/scl_idle_monitor.sv
module scl_idle_monitor
    import busmon_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             scl_i,
    input  logic [CNT_W-1:0] timeout_i,
    output logic             bus_idle_o,
    output logic             idle_pulse_o
);

    logic       scl_sync;
    logic       scl_edge;
    bus_state_e bus_st;

    busmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (scl_i),
        .q_o   (scl_sync)
    );

    busmon_edge u_edge (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .lvl_i  (scl_sync),
        .edge_o (scl_edge)
    );

    busmon_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .edge_i    (scl_edge),
        .timeout_i (timeout_i),
        .state_o   (bus_st),
        .pulse_o   (idle_pulse_o)
    );

    assign bus_idle_o = (bus_st == BUS_IDLE);

    // R6
    pulse_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        idle_pulse_o |=> !idle_pulse_o);

    // R6
    pulse_on_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(bus_idle_o) |-> idle_pulse_o);

    // R6
    rise_on_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        idle_pulse_o |-> $rose(bus_idle_o));

endmodule

// File: tb/scl_idle_monitor_tb.sv
module scl_idle_monitor_tb;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         scl = 1'b1;
    logic [W-1:0] tmo = '0;
    logic         idle;
    logic         pulse;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    scl_idle_monitor #(.CNT_W(W)) u_dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .scl_i        (scl),
        .timeout_i    (tmo),
        .bus_idle_o   (idle),
        .idle_pulse_o (pulse)
    );

    typedef struct packed {
        logic [W-1:0] t;
        logic         lvl;
    } vec_t;

    // level alternates so every entry is a wire change (1 = rising R3, 0 = falling R4)
    localparam vec_t VECS [6] = '{
        '{t: 12'd5,  lvl: 1'b0},
        '{t: 12'd5,  lvl: 1'b1},
        '{t: 12'd0,  lvl: 1'b0},
        '{t: 12'd1,  lvl: 1'b1},
        '{t: 12'd17, lvl: 1'b0},
        '{t: 12'd3,  lvl: 1'b1}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wn(input int n);
        repeat (n) @(negedge clk);
    endtask

    // toggle at current negedge, then follow the window of length t
    task automatic run_window(input logic [W-1:0] t, input logic lvl, input string req);
        tmo = t;
        scl = lvl;
        wn(3);
        chk(req, idle, 1'b0);
        if (t > 0) begin
            wn(int'(t));
            chk("R5 busy before expiry", idle, 1'b0);
            chk("R6 no early pulse", pulse, 1'b0);
        end
        wn(1);
        chk("R5 idle at T+4", idle, 1'b1);
        chk("R6 pulse at idle entry", pulse, 1'b1);
        wn(1);
        chk("R5 idle held", idle, 1'b1);
        chk("R6 pulse one cycle", pulse, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tmo = 12'd3;
        wn(3);
        chk("R1 idle in reset", idle, 1'b0);
        chk("R1 pulse in reset", pulse, 1'b0);
        rst = 1'b0;
        wn(3);
        chk("R2 busy until timeout", idle, 1'b0);
        wn(1);
        chk("R2 idle after reset window", idle, 1'b1);
        chk("R6 pulse after reset window", pulse, 1'b1);
        wn(1);

        foreach (VECS[i]) begin
            run_window(VECS[i].t, VECS[i].lvl, VECS[i].lvl ? "R3 rising restart" : "R4 falling restart");
        end

        // R8: timeout change mid-window has no effect on current window
        tmo = 12'd5;
        scl = 1'b0;
        wn(4);
        tmo = 12'd50;
        wn(4);
        chk("R8 old window still busy", idle, 1'b0);
        wn(1);
        chk("R8 old window expires at old T", idle, 1'b1);
        wn(1);
        run_window(12'd50, 1'b1, "R8 new T after restart");

        // R7: restart lands in the expiry cycle
        tmo = 12'd6;
        scl = 1'b0;
        wn(7);
        scl = 1'b1;
        wn(3);
        chk("R7 restart beats expiry idle", idle, 1'b0);
        chk("R7 restart beats expiry pulse", pulse, 1'b0);
        wn(6);
        chk("R7 fresh window busy", idle, 1'b0);
        wn(1);
        chk("R7 fresh window idle", idle, 1'b1);
        chk("R7 fresh window pulse", pulse, 1'b1);
        wn(1);

        // R9: full-width timeout
        run_window({W{1'b1}}, 1'b0, "R9 max timeout restart");

        // R1: reset while idle
        rst = 1'b1;
        wn(1);
        chk("R1 reset drops idle", idle, 1'b0);
        chk("R1 reset no pulse", pulse, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule